// File: doc/BRIEF.md
# BCH Sector Status Scanner

After a page read, the error-correction engine leaves one status byte per sector, packed four to a 32-bit word in a small bank. This block walks that bank and turns it into per-sector results. A single start pulse sets the page geometry. The block then reads the words it needs in ascending order. For every sector that needs correction, it emits an event carrying the sector index and the symbol error count.

A word that reads as all zero is passed over without looking at its entries. The first sector whose status is not correctable stops the whole scan and marks the page as uncorrectable. Throughout the scan the block sums the error counts of corrected sectors and tracks the largest count in any one sector. Both values come out with a one-cycle done pulse.

The status bank is read through a plain read port with one cycle of latency. Applying the corrections to the data buffer is left to the consumer of the event stream.

Top module: `ecc_sector_scan`

## Requirements
- R1: The sector count is the page size divided by the sector size. `page_size_i` 00 selects 2K, 01 selects 4K, and 10 or 11 select 8K bytes. `sector_1k_i` 0 selects 512-byte sectors and 1 selects 1024-byte sectors. The number of words scanned is the sector count divided by four, with a floor of one. Words are requested one at a time at addresses 0, 1, 2 and so on. Each request is a single-cycle `rd_en_o`, and the data is taken from `rd_data_i` in the following cycle.
- R2: Byte k of status word w (bits 8k+7 down to 8k) describes sector 4w+k. In that byte, bits [1:0] are the status and bits [6:2] are the error count. Bit 7 has no effect.
- R3: A status word equal to zero produces no events. It occupies exactly two busy cycles, the request and the capture.
- R4: An entry with status 00 produces no event and changes neither the total nor the maximum.
- R5: Each entry with status 01 produces exactly one cycle of `evt_valid_o`, carrying its sector index and count. Events come out in ascending sector order, one entry per cycle.
- R6: An entry with status 10 or 11 ends the scan at once: no further events and no further reads. `fail_o` is high together with `done_o` and stays high until the next accepted start. A scan that finds no such entry ends with `fail_o` low.
- R7: `total_o` is the sum of the counts of all events of the current scan, and `max_o` is the largest of those counts. Both are cleared when a start is accepted and hold their values after done.
- R8: `busy_o` is high from the cycle after an accepted start up to and including the single `done_o` cycle. A scan of n words, z of them zero and with no abort, is busy for 2n + 4(n − z) + 1 cycles. `start_i` and the geometry inputs have no effect while busy.
- R9: After reset, `busy_o`, `done_o`, `fail_o`, `evt_valid_o`, `rd_en_o`, `total_o` and `max_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan (taken only when idle) |
| page_size_i | input | 2 | Page size code |
| sector_1k_i | input | 1 | Sector size select: 0 = 512 B, 1 = 1024 B |
| rd_en_o | output | 1 | Status bank read request |
| rd_addr_o | output | ADDR_W | Status word address |
| rd_data_i | input | STAT_W | Status word, valid the cycle after the request |
| evt_valid_o | output | 1 | Correctable sector event |
| evt_sector_o | output | SECT_W | Global sector index of the event |
| evt_count_o | output | CNT_W | Error count of the event |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| fail_o | output | 1 | Page uncorrectable |
| max_o | output | CNT_W | Largest error count in one sector |
| total_o | output | TOT_W | Sum of corrected error counts |

## Verification
The hardest case to reach from the ports is an abort in the middle of a word. The sectors before the bad entry must still be reported and added to the total. Nothing after it may produce an event or a read, even when later bytes and words hold correctable entries. The stimulus for this places a bad status in byte 2 of the first word and in byte 0 of the last word, with correctable entries on both sides. The bench then compares the event list, the read count and the busy length with a model built from the requirements. A second hard case is a new start arriving mid-scan with a different page size. It is injected partway through a four-word scan, and the bench checks that nothing in the result changes.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAPT,
    ST_SCAN,
    ST_DONE
  } scan_state_e;

  typedef enum logic [1:0] {
    ENT_CLEAN,
    ENT_FIX,
    ENT_BAD
  } ent_class_e;
endpackage

// File: rtl/ecc_entry_classify.sv
module ecc_entry_classify
  import ecc_scan_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int CNT_W   = 5
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output ent_class_e         cls_o,
  output logic [CNT_W-1:0]   cnt_o
);
  // R2: status in [1:0], count above it, top bit unused
  always_comb begin
    unique case (entry_i[1:0])
      2'b00:   cls_o = ENT_CLEAN;
      2'b01:   cls_o = ENT_FIX;
      default: cls_o = ENT_BAD;
    endcase
  end

  assign cnt_o = entry_i[2 +: CNT_W];
endmodule

// File: rtl/ecc_err_tally.sv
module ecc_err_tally #(
  parameter int CNT_W = 5,
  parameter int TOT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] max_o,
  output logic [TOT_W-1:0] total_o
);
  // R7
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_o   <= '0;
      total_o <= '0;
    end else if (clear_i) begin
      max_o   <= '0;
      total_o <= '0;
    end else if (add_i) begin
      total_o <= total_o + TOT_W'(cnt_i);
      if (cnt_i > max_o) max_o <= cnt_i;
    end
  end
endmodule

// File: rtl/ecc_scan_fsm.sv
module ecc_scan_fsm
  import ecc_scan_pkg::*;
#(
  parameter int STAT_W    = 32,
  parameter int ENTRY_W   = 8,
  parameter int MAX_WORDS = 4,
  localparam int ENTRIES  = STAT_W / ENTRY_W,
  localparam int BYTE_W   = $clog2(ENTRIES),
  localparam int ADDR_W   = $clog2(MAX_WORDS),
  localparam int WORDS_W  = ADDR_W + 1,
  localparam int SECT_W   = ADDR_W + BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         page_size_i,
  input  logic               sector_1k_i,
  input  logic [STAT_W-1:0]  rd_data_i,
  input  ent_class_e         cls_i,
  output logic               rd_en_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic [ENTRY_W-1:0] entry_o,
  output logic [SECT_W-1:0]  sector_o,
  output logic               scan_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o,
  output logic               clear_o
);
  scan_state_e         state_q;
  logic [ADDR_W-1:0]   word_q;
  logic [BYTE_W-1:0]   byte_q;
  logic [STAT_W-1:0]   stat_q;
  logic [WORDS_W-1:0]  nwords_q;
  logic                fail_q;
  logic [1:0]          pg_eff;
  logic [5:0]          sectors;
  logic [WORDS_W-1:0]  words_calc;
  logic                last_word;
  logic                last_byte;

  // R1: 2K/512 gives four sectors; each page code step doubles it
  always_comb begin
    pg_eff  = (page_size_i == 2'b11) ? 2'b10 : page_size_i;
    sectors = 6'd4 << pg_eff;
    if (sector_1k_i) sectors = sectors >> 1;
    words_calc = (sectors < 6'(ENTRIES)) ? WORDS_W'(1) : WORDS_W'(sectors / 6'(ENTRIES));
  end

  assign last_word = (WORDS_W'(word_q) + WORDS_W'(1)) == nwords_q;
  assign last_byte = byte_q == BYTE_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      word_q   <= '0;
      byte_q   <= '0;
      stat_q   <= '0;
      nwords_q <= '0;
      fail_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          word_q   <= '0;
          nwords_q <= words_calc;
          fail_q   <= 1'b0;
          state_q  <= ST_REQ;
        end
        ST_REQ: state_q <= ST_CAPT;
        ST_CAPT: begin
          stat_q <= rd_data_i;
          byte_q <= '0;
          if (rd_data_i != '0) state_q <= ST_SCAN;
          else if (last_word)  state_q <= ST_DONE;  // R3: zero word skipped
          else begin
            word_q  <= word_q + ADDR_W'(1);
            state_q <= ST_REQ;
          end
        end
        ST_SCAN: begin
          if (cls_i == ENT_BAD) begin               // R6
            fail_q  <= 1'b1;
            state_q <= ST_DONE;
          end else if (last_byte) begin
            if (last_word) state_q <= ST_DONE;
            else begin
              word_q  <= word_q + ADDR_W'(1);
              state_q <= ST_REQ;
            end
          end else begin
            byte_q <= byte_q + BYTE_W'(1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en_o   = state_q == ST_REQ;
  assign rd_addr_o = word_q;
  assign entry_o   = stat_q[byte_q*ENTRY_W +: ENTRY_W];
  assign sector_o  = {word_q, byte_q};
  assign scan_o    = state_q == ST_SCAN;
  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = state_q == ST_DONE;
  assign fail_o    = fail_q;
  assign clear_o   = (state_q == ST_IDLE) && start_i;
endmodule

// File: rtl/ecc_sector_scan.sv
module ecc_sector_scan
  import ecc_scan_pkg::*;
#(
  parameter int STAT_W    = 32,
  parameter int ENTRY_W   = 8,
  parameter int CNT_W     = 5,
  parameter int MAX_WORDS = 4,
  localparam int ENTRIES  = STAT_W / ENTRY_W,
  localparam int ADDR_W   = $clog2(MAX_WORDS),
  localparam int SECT_W   = ADDR_W + $clog2(ENTRIES),
  localparam int TOT_W    = CNT_W + $clog2(MAX_WORDS * ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        page_size_i,
  input  logic              sector_1k_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [STAT_W-1:0] rd_data_i,
  output logic              evt_valid_o,
  output logic [SECT_W-1:0] evt_sector_o,
  output logic [CNT_W-1:0]  evt_count_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  max_o,
  output logic [TOT_W-1:0]  total_o
);
  logic [ENTRY_W-1:0] entry;
  ent_class_e         cls;
  logic               scan;
  logic               clear;

  ecc_scan_fsm #(
    .STAT_W(STAT_W), .ENTRY_W(ENTRY_W), .MAX_WORDS(MAX_WORDS)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .page_size_i, .sector_1k_i, .rd_data_i,
    .cls_i(cls), .rd_en_o, .rd_addr_o, .entry_o(entry), .sector_o(evt_sector_o),
    .scan_o(scan), .busy_o, .done_o, .fail_o, .clear_o(clear)
  );

  ecc_entry_classify #(.ENTRY_W(ENTRY_W), .CNT_W(CNT_W)) u_cls (
    .entry_i(entry), .cls_o(cls), .cnt_o(evt_count_o)
  );

  // R4, R5: only correctable entries raise an event
  assign evt_valid_o = scan && (cls == ENT_FIX);

  ecc_err_tally #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_tally (
    .clk_i, .rst_ni, .clear_i(clear), .add_i(evt_valid_o), .cnt_i(evt_count_o),
    .max_o, .total_o
  );
endmodule

// File: rtl/ecc_sector_scan_chk.sv
module ecc_sector_scan_chk #(
  parameter int CNT_W = 5,
  parameter int TOT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             rd_en_o,
  input logic             evt_valid_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] max_o,
  input logic [TOT_W-1:0] total_o
);
  // R1
  single_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  // R5
  evt_in_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (busy_o && !done_o));
  // R6
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && fail_o) |-> (!evt_valid_o && !rd_en_o));
  // R7
  max_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{(TOT_W-CNT_W){1'b0}}, max_o} <= total_o);
  // R7
  tally_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(total_o) && $stable(max_o)));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
endmodule

bind ecc_sector_scan ecc_sector_scan_chk #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .rd_en_o, .evt_valid_o, .busy_o, .done_o, .fail_o,
  .max_o, .total_o
);

// File: tb/ecc_sector_scan_test.sv
`timescale 1ns/1ps
module ecc_sector_scan_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [1:0]  page = 0;
  logic        s1k = 0;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data = '0;
  logic        evt_valid;
  logic [3:0]  evt_sector;
  logic [4:0]  evt_count;
  logic        busy, done, fail;
  logic [4:0]  max_v;
  logic [8:0]  total_v;
  logic [31:0] mem [4];

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  ecc_sector_scan uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_size_i(page),
    .sector_1k_i(s1k), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .evt_valid_o(evt_valid), .evt_sector_o(evt_sector), .evt_count_o(evt_count),
    .busy_o(busy), .done_o(done), .fail_o(fail), .max_o(max_v), .total_o(total_v)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one scan and compares with a model built from the requirements.
  // poke: cycle index after start at which a stray start with another page code is driven (-1 = none)
  task automatic run_scan(input string name, input logic [1:0] pg, input logic sk,
                          input logic [3:0][31:0] w, input int poke);
    int sectors, words, exp_busy, exp_reads, exp_n, exp_tot, exp_max;
    bit exp_fail, stop;
    int exp_sec[16], exp_cnt[16], got_sec[16], got_cnt[16];
    int got_n, got_reads, got_busy, k, bad_addr;
    logic [7:0] e;
    for (int i = 0; i < 4; i++) mem[i] = w[i];
    // model (R1..R8)
    sectors = 4 << ((pg == 2'b11) ? 2 : pg);
    if (sk) sectors = sectors / 2;
    words = (sectors / 4 < 1) ? 1 : sectors / 4;
    exp_busy = 1; exp_reads = 0; exp_n = 0; exp_tot = 0; exp_max = 0; exp_fail = 0; stop = 0;
    for (int i = 0; i < words && !stop; i++) begin
      exp_reads++; exp_busy += 2;
      if (w[i] == 0) continue;
      for (int b = 0; b < 4 && !stop; b++) begin
        e = w[i][8*b +: 8];
        exp_busy++;
        if (e[1:0] == 2'b01) begin
          exp_sec[exp_n] = 4*i + b; exp_cnt[exp_n] = e[6:2]; exp_n++;
          exp_tot += e[6:2];
          if (e[6:2] > exp_max) exp_max = e[6:2];
        end else if (e[1:0] != 2'b00) begin
          exp_fail = 1; stop = 1;
        end
      end
    end
    // drive
    got_n = 0; got_reads = 0; got_busy = 0; bad_addr = 0; k = 0;
    @(negedge clk);
    page = pg; s1k = sk; start = 1;
    forever begin
      @(negedge clk);
      start = 0;
      if (k == poke) begin start = 1; page = 2'b00; s1k = 1; end
      k++;
      if (busy) got_busy++;
      if (rd_en) begin
        if (rd_addr != 2'(got_reads)) bad_addr++;
        got_reads++;
      end
      if (evt_valid && got_n < 16) begin
        got_sec[got_n] = evt_sector; got_cnt[got_n] = evt_count; got_n++;
      end
      if (done || k > 200) break;
    end
    start = 0;
    chk("R8", {name, " done reached"}, int'(done), 1);
    chk("R6", {name, " fail flag"}, int'(fail), int'(exp_fail));
    chk("R7", {name, " total"}, int'(total_v), exp_tot);
    chk("R7", {name, " max"}, int'(max_v), exp_max);
    chk("R1", {name, " read count"}, got_reads, exp_reads);
    chk("R1", {name, " read order"}, bad_addr, 0);
    chk("R8", {name, " busy cycles"}, got_busy, exp_busy);
    chk("R5", {name, " event count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk("R2", {name, " event sector"}, got_sec[i], exp_sec[i]);
      chk("R5", {name, " event errors"}, got_cnt[i], exp_cnt[i]);
    end
    @(negedge clk);
    chk("R8", {name, " done one cycle"}, int'(done), 0);
    chk("R8", {name, " idle after done"}, int'(busy), 0);
    chk("R7", {name, " total held"}, int'(total_v), exp_tot);
    chk("R6", {name, " fail held"}, int'(fail), int'(exp_fail));
  endtask

  task automatic t_reset;
    chk("R9", "busy", int'(busy), 0);
    chk("R9", "done", int'(done), 0);
    chk("R9", "fail", int'(fail), 0);
    chk("R9", "evt_valid", int'(evt_valid), 0);
    chk("R9", "rd_en", int'(rd_en), 0);
    chk("R9", "total", int'(total_v), 0);
    chk("R9", "max", int'(max_v), 0);
  endtask

  // R3: zero words skipped, 9 busy cycles for four words
  task automatic t_all_zero;
    run_scan("zero_8k", 2'b10, 1'b0, '{32'h0, 32'h0, 32'h0, 32'h0}, -1);
  endtask

  // R2, R4, R5, R7: mixed words; bit 7 ignored (0x85), zero word inside
  task automatic t_mixed;
    run_scan("mixed_8k", 2'b10, 1'b0,
             '{32'h0000_0011, 32'h7D85_0009, 32'h0, 32'h000D_0005}, -1);
  endtask

  // R6: status 10 in byte 2 of word 0, later entries must not count
  task automatic t_abort_mid;
    run_scan("abort_4k", 2'b01, 1'b0, '{32'h0, 32'h0, 32'h0000_0005, 32'h0502_0905}, -1);
  endtask

  // R6: status 11 at byte 0 of last word
  task automatic t_abort_last;
    run_scan("abort_last", 2'b11, 1'b0, '{32'h0000_4503, 32'h0, 32'h0, 32'h1115_0000}, -1);
  endtask

  // R1: geometries, including the one-word floor
  task automatic t_geometry;
    run_scan("2k_1k", 2'b00, 1'b1, '{32'h5, 32'h5, 32'h5, 32'h0900_0001}, -1);
    run_scan("2k_512", 2'b00, 1'b0, '{32'h5, 32'h5, 32'h5, 32'h0000_0400}, -1);
    run_scan("4k_1k", 2'b01, 1'b1, '{32'h5, 32'h5, 32'h5, 32'h0000_0000}, -1);
    run_scan("8k_1k", 2'b10, 1'b1, '{32'h5, 32'h5, 32'h0000_0021, 32'h0000_0000}, -1);
  endtask

  // R8: stray start and new geometry mid-scan have no effect
  task automatic t_restart_ignored;
    run_scan("restart", 2'b10, 1'b0,
             '{32'h0000_0009, 32'h0, 32'h0000_1500, 32'h0000_0005}, 4);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_all_zero;
    t_mixed;
    t_abort_mid;
    t_abort_last;
    t_geometry;
    t_restart_ignored;
    t_mixed;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule